// File: doc/BRIEF.md
# Write-Hit Probe Register Block

This block is a byte-wide register target that answers on two address windows, a memory-mapped one and a port-mapped one, chosen per access by a window-select input. Software arms one of three probe modes by writing a mode code to offset zero. The window used for that write and the code together pick one of six probes. Each armed probe publishes a small header that software reads back one byte at a time. The header holds the probe number, the access width, the address that triggers the probe, the data byte it expects, a 32-bit hit counter and a text name.

After arming, every write that lands on the probe's trigger address and passes the mode's data check adds one to the counter. Host software uses the block to confirm that writes to a given address reach the device. It reads the counter back to see how many arrived and whether the data filter was applied. Read data is registered and returned one cycle after the request.

Top module: `wr_hit_probe`

## Requirements
- R1: After reset no probe is armed, and every read returns 0x00.
- R2: A write to offset 0 with a value v from 0 to 2 arms probe number (window × 3 + v). The memory window is 0 and the port window is 1. Arming clears the hit counter, and header byte 0 then reads the probe number.
- R3: A write to offset 0 with a value of 3 or more disarms the armed probe. All reads then return 0x00 until a probe is armed again.
- R4: The trigger address is the window's base plus the probe number times the access width of 1. The base is 2048 for the memory window and 128 for the port window. Header bytes 4 to 7 hold the trigger address, least significant byte first.
- R5: Mode 1 (any) counts every write to the trigger address, whatever its data and size.
- R6: Modes 0 (none) and 2 (match) count a write to the trigger address only when its data is 0xFA and its size is 1. Header byte 8 holds 0xFA for these modes and 0xCE for mode 1.
- R7: A write to any address other than offset 0 or the armed probe's trigger address leaves the counter and the armed state unchanged. Such a write is also ignored while no probe is armed.
- R8: Header bytes 12 to 15 hold the hit counter, least significant byte first. The counter steps by exactly one per counted write and wraps modulo 2^32.
- R9: Header byte 1 reads 1, and bytes 2, 3, 9, 10 and 11 read 0. From byte 16 the header holds the name "<window>-<mode>" followed by a NUL. The window part is mmio or portio, and the mode part is none, any or match.
- R10: The header length is 17 plus the name length. A read whose address plus size is greater than or equal to that length returns 0x00, so the NUL byte itself also reads as 0x00.
- R11: A read request produces rd_valid for exactly one cycle, on the cycle after the request, with the data in rd_data. No other cycle raises rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_win | input | 1 | Window select: 0 memory, 1 port |
| bus_addr | input | ADDR_W | Byte offset within the window |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |

## Verification
The bench builds the block with its default parameters: a 12-bit offset and window bases of 2048 and 128. With these values all six probes can be armed, and both trigger addresses and full headers can be walked byte by byte, including the unreadable NUL and the bytes past it. A run of three hundred counted writes carries the counter into its second byte. Writes of the wrong size and the wrong data then show the filters of modes 0 and 2 against mode 1.

// File: rtl/wr_hit_probe.sv
module wr_hit_probe #(
  parameter int ADDR_W    = 12,
  parameter int MEM_BASE  = 2048,
  parameter int PORT_BASE = 128,
  parameter int WIDTH     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_win,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2:0]        bus_size,
  input  logic [7:0]        bus_wdata,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);
  localparam logic [7:0] MATCH_BYTE = 8'hFA;
  localparam logic [7:0] ANY_BYTE   = 8'hCE;
  localparam logic [7:0] MODES      = 8'd3;

  logic        act, cur_win;
  logic [1:0]  cur_mode;
  logic [31:0] cnt;

  wire [2:0]  idx   = {1'b0, cur_mode} + (cur_win ? 3'd3 : 3'd0);
  wire [31:0] trig  = (cur_win ? 32'(PORT_BASE) : 32'(MEM_BASE)) + 32'(idx) * 32'(WIDTH);
  wire [31:0] addr32 = 32'(bus_addr);
  wire [7:0]  dat   = (cur_mode == 2'd1) ? ANY_BYTE : MATCH_BYTE;

  wire wr_sel = bus_valid && bus_write && (bus_addr == '0);
  wire wr_hit = bus_valid && bus_write && act && (bus_addr != '0) && (addr32 == trig) &&
                ((cur_mode == 2'd1) || ((bus_wdata == MATCH_BYTE) && (32'(bus_size) == 32'(WIDTH))));

  function automatic int pre_len(logic w);
    return w ? 7 : 5;
  endfunction

  function automatic int suf_len(logic [1:0] m);
    return (m == 2'd0) ? 4 : (m == 2'd1) ? 3 : 5;
  endfunction

  function automatic logic [7:0] name_ch(logic w, logic [1:0] m, int p);
    logic [55:0] pre;
    logic [39:0] suf;
    int pl, sl;
    pre = w ? "portio-" : "mmio-";
    suf = (m == 2'd0) ? "none" : (m == 2'd1) ? "any" : "match";
    pl  = pre_len(w);
    sl  = suf_len(m);
    if (p < 0) return 8'h00;
    if (p < pl) return pre[8*(pl-1-p) +: 8];
    if (p < pl + sl) return suf[8*(pl+sl-1-p) +: 8];
    return 8'h00;
  endfunction

  wire [31:0] hlen = 32'(17 + pre_len(cur_win) + suf_len(cur_mode));
  wire        in_range = act && ((addr32 + 32'(bus_size)) < hlen);

  logic [7:0] hbyte;
  always_comb begin
    hbyte = 8'h00;
    if (addr32 >= 32'd16) hbyte = name_ch(cur_win, cur_mode, int'(addr32) - 16);
    else case (bus_addr[3:0])
      4'd0:  hbyte = {5'd0, idx};
      4'd1:  hbyte = 8'(WIDTH);
      4'd4:  hbyte = trig[7:0];
      4'd5:  hbyte = trig[15:8];
      4'd6:  hbyte = trig[23:16];
      4'd7:  hbyte = trig[31:24];
      4'd8:  hbyte = dat;
      4'd12: hbyte = cnt[7:0];
      4'd13: hbyte = cnt[15:8];
      4'd14: hbyte = cnt[23:16];
      4'd15: hbyte = cnt[31:24];
      default: hbyte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act      <= 1'b0;
      cur_win  <= 1'b0;
      cur_mode <= 2'd0;
      cnt      <= '0;
    end else if (wr_sel) begin
      act <= bus_wdata < MODES;
      if (bus_wdata < MODES) begin
        cur_win  <= bus_win;
        cur_mode <= bus_wdata[1:0];
        cnt      <= '0;
      end
    end else if (wr_hit) begin
      cnt <= cnt + 32'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      rd_valid <= bus_valid && !bus_write;
      rd_data  <= (bus_valid && !bus_write && in_range) ? hbyte : 8'h00;
    end
  end
endmodule

// File: rtl/wr_hit_probe_chk.sv
module wr_hit_probe_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              rd_valid,
  input logic [7:0]        rd_data,
  input logic              act,
  input logic [31:0]       cnt
);
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && bus_addr == '0 && bus_wdata < 8'd3 |=> act && cnt == 32'd0); // R2
  AST_HIGH_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && bus_addr == '0 && bus_wdata >= 8'd3 |=> !act); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != $past(cnt) |-> (cnt == $past(cnt) + 32'd1) || (cnt == 32'd0)); // R8
  AST_IDLE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && bus_addr != '0 && !act |=> $stable(cnt) && !act); // R7
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_write && !act |=> rd_valid && rd_data == 8'h00); // R1
  AST_RD_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !rd_valid); // R11
endmodule

bind wr_hit_probe wr_hit_probe_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
  .rd_data(rd_data), .act(act), .cnt(cnt)
);

// File: tb/test_wr_hit_probe.sv
`timescale 1ns/1ps
module test_wr_hit_probe;
  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0, bus_win = 0;
  logic [11:0] bus_addr = '0;
  logic [2:0] bus_size = 3'd1;
  logic [7:0] bus_wdata = '0;
  logic rd_valid;
  logic [7:0] rd_data;

  always #4 clk = ~clk;

  wr_hit_probe i_wr_hit_probe (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_win(bus_win), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data));

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  bit m_act = 0, m_win = 0;
  int m_mode = 0;
  logic [31:0] m_cnt = 0;

  function automatic string m_name();
    string w, m;
    w = m_win ? "portio" : "mmio";
    m = (m_mode == 0) ? "none" : (m_mode == 1) ? "any" : "match";
    return {w, "-", m};
  endfunction

  function automatic int m_idx(); return m_win * 3 + m_mode; endfunction
  function automatic int m_trig(); return (m_win ? 128 : 2048) + m_idx(); endfunction
  function automatic int m_hlen(); return 17 + m_name().len(); endfunction

  function automatic logic [7:0] m_byte(int a, int sz);
    logic [31:0] t;
    string n;
    if (!m_act || a + sz >= m_hlen()) return 8'h00;
    t = m_trig();
    n = m_name();
    if (a >= 16) return (a - 16 < n.len()) ? n[a-16] : 8'h00;
    case (a)
      0: return 8'(m_idx());
      1: return 8'd1;
      4: return t[7:0];
      5: return t[15:8];
      6: return t[23:16];
      7: return t[31:24];
      8: return (m_mode == 1) ? 8'hCE : 8'hFA;
      12: return m_cnt[7:0];
      13: return m_cnt[15:8];
      14: return m_cnt[23:16];
      15: return m_cnt[31:24];
      default: return 8'h00;
    endcase
  endfunction

  task automatic wr(bit win, int a, logic [7:0] d, int sz = 1);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_win = win; bus_addr = 12'(a);
    bus_wdata = d; bus_size = 3'(sz);
    if (a == 0) begin
      m_act = d < 3;
      if (m_act) begin m_win = win; m_mode = int'(d); m_cnt = 0; end
    end else if (m_act && a == m_trig() && (m_mode == 1 || (d == 8'hFA && sz == 1)))
      m_cnt = m_cnt + 1;
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic rd(bit win, int a, string tag, int sz = 1);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_win = win; bus_addr = 12'(a); bus_size = 3'(sz);
    exp_q.push_back(m_byte(a, sz));
    tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      logic [7:0] e;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R11: rd_valid without request, got %02h expected none", rd_data);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s: rd_data %02h expected %02h", t, rd_data, e);
        end
      end
    end
  end

  task automatic walk(string tag);
    for (int a = 0; a < m_hlen() + 2; a++) rd(m_win, a, tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, 0, "R1"); rd(0, 16, "R1"); rd(1, 8, "R1");
    wr(0, 2048, 8'hFA);
    rd(0, 12, "R7 idle write");

    wr(0, 0, 8'd1);
    walk("R2 R4 R9 R10");
    wr(0, 2049, 8'h00); wr(0, 2049, 8'h55); wr(0, 2049, 8'hFA, 2);
    rd(0, 12, "R5");
    wr(0, 2050, 8'hFA); wr(1, 5, 8'h01); wr(0, 2048, 8'hFA);
    rd(0, 12, "R7"); rd(0, 0, "R7");
    rd(0, 8, "R6"); rd(0, 27, "R10 size"); rd(0, 26, "R10 size", 2);

    wr(0, 0, 8'd2);
    rd(0, 12, "R2 cleared");
    wr(0, 2050, 8'hFA); wr(0, 2050, 8'h12); wr(0, 2050, 8'hFA, 2); wr(0, 2050, 8'hCE);
    rd(0, 12, "R6"); walk("R2 R4 R6 R9");

    wr(1, 0, 8'd0);
    wr(1, 131, 8'hFA); wr(1, 131, 8'hFA); wr(1, 131, 8'h00); wr(1, 132, 8'hFA);
    walk("R2 R6 R4 R9");

    wr(1, 0, 8'd1);
    for (int i = 0; i < 300; i++) wr(1, 132, 8'(i));
    rd(1, 12, "R8"); rd(1, 13, "R8"); rd(1, 14, "R8");
    walk("R2 R5 R8 R9");
    wr(0, 0, 8'd0);
    walk("R2 R9");
    wr(1, 0, 8'd2);
    walk("R2 R9");

    wr(1, 0, 8'd3);
    rd(1, 0, "R3"); rd(1, 16, "R3"); rd(0, 8, "R3");
    wr(1, 133, 8'hFA);
    wr(1, 0, 8'd2);
    rd(1, 12, "R3 rearm");
    wr(1, 133, 8'hFA);
    rd(1, 12, "R6");
    wr(0, 0, 8'hFF);
    rd(0, 12, "R3");

    wr(0, 0, 8'd1);
    @(negedge clk); rst_n = 0; m_act = 0;
    @(negedge clk); rst_n = 1;
    rd(0, 0, "R1 reset"); rd(0, 8, "R1 reset");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R11: %0d reads without data, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule